// File: doc/BRIEF.md
# GPIO Edge and Level Event Detector

This block watches a set of general-purpose input pins and records interrupt events for each of them. The pins are split into banks of 32 bits. The default configuration has 54 pins, so it builds two banks, and the upper bank populates only its low 22 bits. Each pin passes through a two-flop synchronizer. It can then be armed for any mix of four conditions: a rising edge, a falling edge, a high level or a low level. Arming rising and falling together on one pin gives double-edge detection.

A detected condition sets a sticky bit in the bank's status register. Software clears that bit by writing a 1 to it. Each bank raises its own interrupt line while any of its status bits is set. Edge events stay clear once they are cleared. A level event sets its bit again on every cycle that the armed level persists, so software must remove the level before a clear has a lasting effect.

A flat register port gives access to the registers. The address is split as {bank index, 3-bit register select}. The select codes are 0 = rising enable, 1 = falling enable, 2 = high enable, 3 = low enable and 4 = status. Reads are combinational.

Top module: `gpio_evt_detect`

## Requirements
- R1: Pin n maps to bank n/32, bit n%32. Every register resets to zero. Bits above the last implemented pin read zero and ignore writes (with 54 pins, bank 1 reads back 0x003FFFFF after writing all ones).
- R2: With the rising enable set, a 0-to-1 change of a pin sets its status bit. A 1-to-0 change does not.
- R3: With the falling enable set, a 1-to-0 change of a pin sets its status bit. A 0-to-1 change does not.
- R4: With both edge enables set, either direction of change sets the status bit.
- R5: With the high enable set, the status bit is set while the pin is high and stays set after a clear for as long as the pin stays high.
- R6: With the low enable set, the status bit is set while the pin is low and stays set after a clear for as long as the pin stays low.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R8: When an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R9: A bank's interrupt output is high exactly when that bank's status register is nonzero, and it is independent of the other banks.
- R10: A status bit sets on the third rising clock edge after the pin changes, and not earlier.
- R11: A pin with no enable set never sets its status bit.
- R12: Select codes 5 to 7 read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PINS | Asynchronous pin inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | {bank index, 3-bit select} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| irq_o | output | NBANKS | One interrupt per bank |

## Verification
A pin change reaches the first synchronizer flop on the first edge and the second flop on the second edge. The status bit and the interrupt change on the third edge. The bench therefore samples at falling edges: once after two edges, where the bit must still be clear, and once after three, where it must be set. A register write commits on the edge after the strobe, so every read-back after a write or clear is taken at the following falling edge. In the same-cycle test, the clear strobe is placed so that it commits on exactly the edge that records the event.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
    localparam int BANK_BITS = 32;
    localparam int SEL_W     = 3;

    localparam logic [SEL_W-1:0] SEL_RISE = 3'd0;
    localparam logic [SEL_W-1:0] SEL_FALL = 3'd1;
    localparam logic [SEL_W-1:0] SEL_HIGH = 3'd2;
    localparam logic [SEL_W-1:0] SEL_LOW  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_STAT = 3'd4;

    typedef logic [BANK_BITS-1:0] bank_vec_t;

    typedef struct packed {
        bank_vec_t rise_en;
        bank_vec_t fall_en;
        bank_vec_t high_en;
        bank_vec_t low_en;
        bank_vec_t status;
        bank_vec_t prev;
    } bank_state_t;
endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
    import gpio_evt_pkg::*;
#(
    parameter int ACTIVE = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bank_vec_t        pin_s,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  bank_vec_t        wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output bank_vec_t        rd_data,
    output logic             irq
);
    localparam bank_vec_t MASK = (ACTIVE >= BANK_BITS) ? '1 :
                                 bank_vec_t'((64'd1 << ACTIVE) - 64'd1);

    bank_state_t st_d, st_q;
    bank_vec_t   evt;
    bank_vec_t   clr;

    always_comb begin
        st_d = st_q;
        clr  = '0;
        evt  = (st_q.rise_en &  pin_s & ~st_q.prev)
             | (st_q.fall_en & ~pin_s &  st_q.prev)
             | (st_q.high_en &  pin_s)
             | (st_q.low_en  & ~pin_s);
        if (wr_en) begin
            case (wr_sel)
                SEL_RISE: st_d.rise_en = wr_data & MASK;
                SEL_FALL: st_d.fall_en = wr_data & MASK;
                SEL_HIGH: st_d.high_en = wr_data & MASK;
                SEL_LOW:  st_d.low_en  = wr_data & MASK;
                SEL_STAT: clr          = wr_data;
                default:  ;
            endcase
        end
        st_d.status = ((st_q.status & ~clr) | evt) & MASK;
        st_d.prev   = pin_s & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (rd_sel)
            SEL_RISE: rd_data = st_q.rise_en;
            SEL_FALL: rd_data = st_q.fall_en;
            SEL_HIGH: rd_data = st_q.high_en;
            SEL_LOW:  rd_data = st_q.low_en;
            SEL_STAT: rd_data = st_q.status;
            default:  rd_data = '0;
        endcase
    end

    assign irq = |st_q.status;

    a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(st_q.rise_en & pin_s & ~st_q.prev) & ~st_q.status) == '0));

    a_r3_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(st_q.fall_en & ~pin_s & st_q.prev) & ~st_q.status) == '0));

    a_r5_high_holds: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(st_q.high_en & pin_s) & ~st_q.status) == '0));

    a_r6_low_holds: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(st_q.low_en & ~pin_s) & ~st_q.status) == '0));

    a_r11_no_unarmed_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.status & ~$past(st_q.status) &
                   ~$past(st_q.rise_en | st_q.fall_en | st_q.high_en | st_q.low_en)) == '0));
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
    import gpio_evt_pkg::*;
#(
    parameter  int NUM_PINS   = 54,
    localparam int NBANKS     = (NUM_PINS + BANK_BITS - 1) / BANK_BITS,
    localparam int BANK_IDX_W = (NBANKS > 1) ? $clog2(NBANKS) : 1,
    localparam int ADDR_W     = BANK_IDX_W + SEL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PINS-1:0]  pins_i,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [BANK_BITS-1:0] reg_wdata,
    output logic [BANK_BITS-1:0] reg_rdata,
    output logic [NBANKS-1:0]    irq_o
);
    localparam int PAD_W = NBANKS * BANK_BITS;

    logic [NUM_PINS-1:0]   pins_s;
    logic [PAD_W-1:0]      pins_pad;
    logic [BANK_IDX_W-1:0] bank_idx;
    logic [SEL_W-1:0]      sel;
    bank_vec_t             bank_rd [NBANKS];

    assign bank_idx = reg_addr[ADDR_W-1:SEL_W];
    assign sel      = reg_addr[SEL_W-1:0];

    gpio_evt_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins_i),
        .dout  (pins_s)
    );

    always_comb begin
        pins_pad = '0;
        pins_pad[NUM_PINS-1:0] = pins_s;
    end

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        localparam int REMAIN = NUM_PINS - b * BANK_BITS;
        localparam int ACT    = (REMAIN > BANK_BITS) ? BANK_BITS : REMAIN;

        gpio_evt_bank #(.ACTIVE(ACT)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_s   (pins_pad[b*BANK_BITS +: BANK_BITS]),
            .wr_en   (reg_we && (bank_idx == BANK_IDX_W'(b))),
            .wr_sel  (sel),
            .wr_data (reg_wdata),
            .rd_sel  (sel),
            .rd_data (bank_rd[b]),
            .irq     (irq_o[b])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NBANKS; b++) begin
            if (bank_idx == BANK_IDX_W'(b)) begin
                reg_rdata = bank_rd[b];
            end
        end
    end

    a_r9_irq_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_o == '0));
endmodule

// File: tb/tb_gpio_evt_detect.sv
`timescale 1ns/1ps
module tb_gpio_evt_detect;
    localparam int NP = 54;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = '0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [1:0]    irq_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    gpio_evt_detect #(.NUM_PINS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int k, input int sel, input logic [31:0] d);
        reg_addr  = AW'((k << 3) | sel);
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input int k, input int sel, output logic [31:0] v);
        reg_addr = AW'((k << 3) | sel);
        #1;
        v = reg_rdata;
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        for (int k = 0; k < 2; k++)
            for (int s = 0; s < 5; s++) begin
                rd(k, s, v);
                chk("R1 reset value", v, 32'h0);
            end
        chk("R9 irq after reset", {30'h0, irq_o}, 32'h0);

        // R1 unimplemented bits
        wr(1, 0, 32'hFFFF_FFFF);
        rd(1, 0, v); chk("R1 bank1 mask", v, 32'h003F_FFFF);
        wr(0, 0, 32'hFFFF_FFFF);
        rd(0, 0, v); chk("R1 bank0 full", v, 32'hFFFF_FFFF);
        wr(0, 0, 0); wr(1, 0, 0);

        // R12 unused selects
        for (int s = 5; s < 8; s++) begin
            wr(0, s, 32'hFFFF_FFFF);
            rd(0, s, v); chk("R12 unused reads zero", v, 32'h0);
        end
        for (int s = 0; s < 5; s++) begin
            rd(0, s, v); chk("R12 no side effect", v, 32'h0);
        end

        // R11 unarmed pin
        wr(0, 0, 32'h8);
        pins[4] = 1'b1; idle(4);
        rd(0, 4, v); chk("R11 unarmed pin", v, 32'h0);
        pins[4] = 1'b0; idle(4);
        wr(0, 0, 0);

        // R8 set wins over clear in same cycle
        wr(0, 0, 32'h20);
        pins[5] = 1'b1;
        idle(2);
        reg_addr = AW'(4); reg_wdata = 32'h20; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        rd(0, 4, v); chk("R8 set wins", v, 32'h20);
        wr(0, 4, 32'h20);
        rd(0, 4, v); chk("R7 clear after race", v, 32'h0);
        wr(0, 0, 0); pins[5] = 1'b0; idle(4);

        // sweep all pins x modes: 0 rise, 1 fall, 2 both, 3 high, 4 low
        for (int p = 0; p < NP; p++) begin
            for (int m = 0; m < 5; m++) begin
                int k, b;
                logic iv;
                logic [31:0] bit_m;
                logic [31:0] exp_back;
                k = p / 32; b = p % 32;
                bit_m = 32'h1 << b;
                iv = (m == 1 || m == 4);
                pins[p] = iv; idle(4);
                wr(k, 4, 32'hFFFF_FFFF);
                if (m == 0 || m == 2) wr(k, 0, bit_m);
                if (m == 1 || m == 2) wr(k, 1, bit_m);
                if (m == 3) wr(k, 2, bit_m);
                if (m == 4) wr(k, 3, bit_m);
                idle(3);
                rd(k, 4, v); chk("R11 idle no event", v, 32'h0);
                pins[p] = ~iv;
                idle(2);
                rd(k, 4, v); chk("R10 not before third edge", v, 32'h0);
                idle(1);
                rd(k, 4, v);
                case (m)
                    0: chk("R2 rising sets", v, bit_m);
                    1: chk("R3 falling sets", v, bit_m);
                    2: chk("R4 double first edge", v, bit_m);
                    3: chk("R5 high sets", v, bit_m);
                    default: chk("R6 low sets", v, bit_m);
                endcase
                chk("R9 irq own bank", {31'h0, irq_o[k]}, 32'h1);
                chk("R9 irq other bank", {31'h0, irq_o[1-k]}, 32'h0);
                wr(k, 4, 32'h0);
                rd(k, 4, v); chk("R7 zero write keeps", v, bit_m);
                wr(k, 4, bit_m);
                rd(k, 4, v);
                if (m == 3) chk("R5 level survives clear", v, bit_m);
                else if (m == 4) chk("R6 level survives clear", v, bit_m);
                else begin
                    chk("R7 edge clears", v, 32'h0);
                    chk("R9 irq drops", {31'h0, irq_o[k]}, 32'h0);
                end
                pins[p] = iv;
                idle(3);
                exp_back = (m == 0 || m == 1) ? 32'h0 : bit_m;
                rd(k, 4, v);
                case (m)
                    0: chk("R2 falling ignored", v, exp_back);
                    1: chk("R3 rising ignored", v, exp_back);
                    2: chk("R4 double second edge", v, exp_back);
                    3: chk("R5 sticky after release", v, exp_back);
                    default: chk("R6 sticky after release", v, exp_back);
                endcase
                wr(k, 4, bit_m);
                rd(k, 4, v); chk("R7 final clear", v, 32'h0);
                for (int s = 0; s < 4; s++) wr(k, s, 0);
                pins[p] = 1'b0; idle(4);
                wr(k, 4, 32'hFFFF_FFFF);
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule